// File: doc/BRIEF.md
# Programmable Pin Input Deglitch Filter

This block cleans up one general-purpose input pin before its level is used by status and interrupt logic. The pin is first brought into the system clock domain by a two-stage synchronizer. A filter stage then decides when a new level may reach the output. Timing is measured with a slow real-time tick, which arrives as a one-cycle enable pulse in the system clock domain.

Software sets three fields. A two-bit filter mode picks bypass, symmetric glitch removal, or one-sided filtering: short low pulses are kept, or short high pulses are kept. A two-bit unit select picks how many real-time ticks make one timer unit. A four-bit count sets how many units a new level must stay stable before it is accepted.

Any change to these fields restarts the filter from the current synchronized pin level. The filtered level is the only output. It also serves as the pin-status value that software reads.

Top module: `pin_deglitch_filter`

## Requirements
- R1: While reset is asserted (rst_n low at a clock edge), the filtered output and both synchronizer stages are cleared to 0.
- R2: Mode encoding 2'b00 is bypass. In bypass the output equals the raw pin as it was sampled three clock edges earlier: two synchronizer flops plus the output register.
- R3: A count field of 0 makes every filtering mode behave as bypass, with the same three-edge latency.
- R4: The unit select is {large, small}. 2'b00 means 2 ticks per unit, 2'b01 means 8, 2'b10 means 512 and 2'b11 means 2048.
- R5: In mode 2'b01 (remove glitches), a new synchronized level reaches the output on the clock edge that samples the (count × unit)-th tick counted from the moment the synchronized input first differs from the output. It never reaches the output earlier.
- R6: If the synchronized input returns to the output level before the debounce time expires, the partial count is thrown away. A tick that arrives once the input is back at the output level does not change the output. The next change needs the full debounce time again.
- R7: In mode 2'b10 (keep low glitches), a falling level passes with bypass latency and no ticks. A rising level is filtered as in R5.
- R8: In mode 2'b11 (keep high glitches), a rising level passes with bypass latency and no ticks. A falling level is filtered as in R5.
- R9: Any change of mode, unit select or count makes the output load the synchronized input at the next clock edge. The stability count then restarts under the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_raw | input | 1 | Asynchronous raw pin level |
| rtc_tick | input | 1 | One-cycle real-time tick enable, synchronous to clk |
| filt_mode | input | 2 | Filter mode: 00 bypass, 01 remove, 10 keep low, 11 keep high |
| unit_sel | input | 2 | Timer unit select {large, small} |
| db_count | input | 4 | Number of timer units a new level must hold |
| pin_filtered | output | 1 | Filtered pin level, also the pin-status value |

## Verification
Two events can fall in the same cycle: the expiring tick of the stability counter, and the synchronized input falling back to the output level. The bench provokes this by counting one tick short of the debounce time. It then reverts the pin and lands the last tick exactly on the first edge at which the reverted level has left the synchronizer. The output must keep its old level, because a tick only counts while the input still differs. A second collision, between a settings change and a pending count, is judged by the output snapping to the synchronized pin level and then needing the full new debounce time.

// File: rtl/deb_pkg.sv
// Shared types and helpers for the pin deglitch filter.
// Assumes the mode field is two bits wide and encoded as listed below.
package deb_pkg;

    typedef enum logic [1:0] {
        DB_BYPASS    = 2'b00,
        DB_REMOVE    = 2'b01,
        DB_KEEP_LOW  = 2'b10,
        DB_KEEP_HIGH = 2'b11
    } db_mode_e;

    // Largest of four tick counts; used to size the prescaler.
    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/deb_sync.sv
// Multi-stage synchronizer for one asynchronous input bit.
// Assumes the input may change at any time; the last stage is safe to use.
module deb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] stage;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift the pin level one flop further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage[g] <= 1'b0;
                end else if (g == 0) begin
                    stage[g] <= d_async;
                end else begin
                    stage[g] <= stage[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage[STAGES-1];
endmodule

// File: rtl/deb_prescale.sv
// Divides real-time ticks into timer units of a selectable size.
// Counts only while run is high; clr or idle return it to zero.
// unit_tick is a one-cycle pulse on the tick that closes a unit.
module deb_prescale #(
    parameter int unsigned UNIT0_TICKS = 2,
    parameter int unsigned UNIT1_TICKS = 8,
    parameter int unsigned UNIT2_TICKS = 512,
    parameter int unsigned UNIT3_TICKS = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       run,
    input  logic       rtc_tick,
    input  logic [1:0] unit_sel,
    output logic       unit_tick
);
    localparam int unsigned MAX_TICKS =
        deb_pkg::max4(UNIT0_TICKS, UNIT1_TICKS, UNIT2_TICKS, UNIT3_TICKS);
    localparam int unsigned PRE_W = (MAX_TICKS > 2) ? $clog2(MAX_TICKS) : 1;
    localparam int unsigned UNITS [4] = '{UNIT0_TICKS, UNIT1_TICKS, UNIT2_TICKS, UNIT3_TICKS};

    logic [PRE_W-1:0] pre_cnt;
    logic [3:0]       at_end;
    logic             last_tick;

    genvar g;
    generate
        for (g = 0; g < 4; g++) begin : g_unit
            assign at_end[g] = (pre_cnt == PRE_W'(UNITS[g] - 1));
        end
    endgenerate

    // Choose the terminal compare for the selected unit.
    always_comb begin
        last_tick = at_end[unit_sel];
        unit_tick = run && rtc_tick && last_tick;
    end

    // Count ticks inside the current unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (clr || !run) begin
            pre_cnt <= '0;
        end else if (rtc_tick) begin
            pre_cnt <= last_tick ? '0 : pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/deb_core.sv
// Stability counter and mode handling for the filtered level.
// Assumes s_in is already synchronous. The output register loads s_in at
// once in bypass, on a settings change, or for a pass-through edge.
// Otherwise it loads s_in after count units of stable difference.
module deb_core #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_in,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] count,
    input  logic             cfg_chg,
    input  logic             unit_tick,
    output logic             run,
    output logic             filt,
    output logic [CNT_W-1:0] unit_cnt
);
    import deb_pkg::*;

    db_mode_e mode_e;
    logic     bypass;
    logic     differ;
    logic     fast;

    // Decode the mode and classify the current input against the output.
    always_comb begin
        mode_e = db_mode_e'(mode);
        bypass = (mode_e == DB_BYPASS) || (count == '0);
        differ = (s_in != filt);
        fast   = ((mode_e == DB_KEEP_LOW)  && !s_in) ||
                 ((mode_e == DB_KEEP_HIGH) &&  s_in);
        run    = !bypass && differ && !fast && !cfg_chg;
    end

    // Update the filtered level and the unit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt     <= 1'b0;
            unit_cnt <= '0;
        end else if (cfg_chg || bypass || fast) begin
            filt     <= s_in;
            unit_cnt <= '0;
        end else if (!differ) begin
            unit_cnt <= '0;
        end else if (unit_tick) begin
            if (unit_cnt == count - CNT_W'(1)) begin
                filt     <= s_in;
                unit_cnt <= '0;
            end else begin
                unit_cnt <= unit_cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/pin_deglitch_filter.sv
// Top of the pin deglitch filter: synchronizer, settings-change detect,
// tick prescaler and stability core.
// Assumes rtc_tick is a one-cycle pulse already in the clk domain.
module pin_deglitch_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 4,
    parameter int unsigned UNIT0_TICKS = 2,
    parameter int unsigned UNIT1_TICKS = 8,
    parameter int unsigned UNIT2_TICKS = 512,
    parameter int unsigned UNIT3_TICKS = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_raw,
    input  logic             rtc_tick,
    input  logic [1:0]       filt_mode,
    input  logic [1:0]       unit_sel,
    input  logic [CNT_W-1:0] db_count,
    output logic             pin_filtered
);
    localparam int unsigned CFG_W = 4 + CNT_W;

    logic             pin_sync;
    logic [CFG_W-1:0] cfg_now;
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_chg;
    logic             run;
    logic             unit_tick;
    logic [CNT_W-1:0] unit_cnt;

    deb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_raw),
        .q_sync  (pin_sync)
    );

    // Spot any change of the software settings.
    always_comb begin
        cfg_now = {filt_mode, unit_sel, db_count};
        cfg_chg = (cfg_now != cfg_q);
    end

    // Remember the settings seen at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_now;
        end
    end

    deb_prescale #(
        .UNIT0_TICKS (UNIT0_TICKS),
        .UNIT1_TICKS (UNIT1_TICKS),
        .UNIT2_TICKS (UNIT2_TICKS),
        .UNIT3_TICKS (UNIT3_TICKS)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cfg_chg),
        .run       (run),
        .rtc_tick  (rtc_tick),
        .unit_sel  (unit_sel),
        .unit_tick (unit_tick)
    );

    deb_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_in      (pin_sync),
        .mode      (filt_mode),
        .count     (db_count),
        .cfg_chg   (cfg_chg),
        .unit_tick (unit_tick),
        .run       (run),
        .filt      (pin_filtered),
        .unit_cnt  (unit_cnt)
    );
endmodule

// File: rtl/pin_deglitch_filter_chk.sv
// Property checker for the pin deglitch filter, bound to every instance.
// Assumes the default two-stage synchronizer for the bypass latency check.
module pin_deglitch_filter_chk #(
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pin_raw,
    input logic             rtc_tick,
    input logic [1:0]       filt_mode,
    input logic [CNT_W-1:0] db_count,
    input logic             pin_filtered,
    input logic             pin_sync,
    input logic             cfg_chg,
    input logic [CNT_W-1:0] unit_cnt
);
    logic [2:0] since_rst;

    // Count cycles since reset so that $past never looks before it.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // R2: bypass output is the pin three edges back
    a_r2_bypass_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && $past(filt_mode) == 2'b00 && !$past(cfg_chg))
        |-> pin_filtered == $past(pin_raw, 3));

    // R5: in remove mode the output moves only on a tick
    a_r5_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd2 && !$stable(pin_filtered) && $past(filt_mode) == 2'b01 &&
         $past(db_count) != '0 && !$past(cfg_chg))
        |-> $past(rtc_tick));

    // R5: the unit counter stays below the programmed count
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_chg && db_count != '0) |-> unit_cnt < db_count);

    // R7: in keep-low mode a rise needs a tick
    a_r7_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd2 && $rose(pin_filtered) && $past(filt_mode) == 2'b10 &&
         $past(db_count) != '0 && !$past(cfg_chg))
        |-> $past(rtc_tick));

    // R8: in keep-high mode a fall needs a tick
    a_r8_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd2 && $fell(pin_filtered) && $past(filt_mode) == 2'b11 &&
         $past(db_count) != '0 && !$past(cfg_chg))
        |-> $past(rtc_tick));

    // R9: a settings change loads the synchronized level
    a_r9_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd2 && $past(cfg_chg)) |-> pin_filtered == $past(pin_sync));
endmodule

bind pin_deglitch_filter pin_deglitch_filter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_raw      (pin_raw),
    .rtc_tick     (rtc_tick),
    .filt_mode    (filt_mode),
    .db_count     (db_count),
    .pin_filtered (pin_filtered),
    .pin_sync     (pin_sync),
    .cfg_chg      (cfg_chg),
    .unit_cnt     (unit_cnt)
);

// File: tb/tb_pin_deglitch_filter.sv
`timescale 1ns/1ps
module tb_pin_deglitch_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_raw = 1'b0;
    logic       rtc_tick = 1'b0;
    logic [1:0] filt_mode = 2'b00;
    logic [1:0] unit_sel = 2'b00;
    logic [3:0] db_count = 4'd0;
    logic       pin_filtered;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pin_deglitch_filter dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_raw      (pin_raw),
        .rtc_tick     (rtc_tick),
        .filt_mode    (filt_mode),
        .unit_sel     (unit_sel),
        .db_count     (db_count),
        .pin_filtered (pin_filtered)
    );

    function automatic int unit_ticks(input logic [1:0] u);
        case (u)
            2'b00: return 2;
            2'b01: return 8;
            2'b10: return 512;
            default: return 2048;
        endcase
    endfunction

    function automatic int need_ticks(input logic [1:0] u, input logic [3:0] c);
        return int'(c) * unit_ticks(u);
    endfunction

    function automatic logic passes_fast(input logic [1:0] m, input logic lvl);
        return (m == 2'b10 && !lvl) || (m == 2'b11 && lvl);
    endfunction

    task automatic chk(input string req, input logic exp);
        checks++;
        if (pin_filtered !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, pin_filtered, exp);
        end
    endtask

    // Change the pin and let it clear the synchronizer and output register.
    task automatic drive_pin(input logic v);
        @(negedge clk) pin_raw = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            rtc_tick = 1'b1;
            @(negedge clk) rtc_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic [1:0] u, input logic [3:0] c);
        @(negedge clk);
        filt_mode = m; unit_sel = u; db_count = c;
        repeat (2) @(negedge clk);
    endtask

    // Filtered transition: one tick short keeps old, the last one commits.
    task automatic filtered_step(input string req, input logic newlvl);
        int n;
        n = need_ticks(unit_sel, db_count);
        drive_pin(newlvl);
        ticks(n - 1);
        chk(req, !newlvl);
        ticks(1);
        chk(req, newlvl);
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk("R1 reset", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 1'b0);

        // R2 bypass follows pin with no ticks
        drive_pin(1'b1); chk("R2 bypass rise", 1'b1);
        drive_pin(1'b0); chk("R2 bypass fall", 1'b0);

        // R3 count zero acts as bypass
        set_cfg(2'b01, 2'b01, 4'd0);
        drive_pin(1'b1); chk("R3 zero count rise", 1'b1);
        drive_pin(1'b0); chk("R3 zero count fall", 1'b0);

        // R5 with R4 unit 00 and 01
        set_cfg(2'b01, 2'b00, 4'd3);
        filtered_step("R5 R4 unit00 rise", 1'b1);
        filtered_step("R5 R4 unit00 fall", 1'b0);
        set_cfg(2'b01, 2'b01, 4'd2);
        filtered_step("R5 R4 unit01 rise", 1'b1);
        filtered_step("R5 R4 unit01 fall", 1'b0);

        // R4 large units
        set_cfg(2'b01, 2'b10, 4'd2);
        filtered_step("R4 unit10", 1'b1);
        set_cfg(2'b01, 2'b11, 4'd1);
        filtered_step("R4 unit11", 1'b0);

        // R6 glitch rejected and count restarts
        set_cfg(2'b01, 2'b00, 4'd4);
        drive_pin(1'b1); ticks(7);
        drive_pin(1'b0); chk("R6 glitch rejected", 1'b0);
        drive_pin(1'b1); ticks(7); chk("R6 restart needs full time", 1'b0);
        ticks(1); chk("R6 restart commit", 1'b1);

        // R6 last tick lands as input returns
        drive_pin(1'b0); ticks(7);
        @(negedge clk) pin_raw = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk) rtc_tick = 1'b1;
        @(negedge clk) rtc_tick = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 coincident tick ignored", 1'b1);

        // R7 keep low: fall fast, rise filtered
        set_cfg(2'b10, 2'b00, 4'd3);
        drive_pin(1'b0); chk("R7 fall passes", 1'b0);
        filtered_step("R7 rise filtered", 1'b1);
        drive_pin(1'b0); chk("R7 fall passes again", 1'b0);

        // R8 keep high: rise fast, fall filtered
        set_cfg(2'b11, 2'b01, 4'd1);
        drive_pin(1'b1); chk("R8 rise passes", 1'b1);
        filtered_step("R8 fall filtered", 1'b0);

        // R9 settings change loads synchronized level, count restarts
        set_cfg(2'b01, 2'b00, 4'd5);
        drive_pin(1'b1); ticks(3);
        chk("R9 pending before change", 1'b0);
        set_cfg(2'b01, 2'b00, 4'd6);
        chk("R9 load on change", 1'b1);
        filtered_step("R9 new count", 1'b0);

        // Random mix over modes, small units and counts
        for (int it = 0; it < 24; it++) begin
            logic [1:0] m;
            logic [1:0] u;
            logic [3:0] c;
            logic       nl;
            m  = 2'(1 + ($urandom % 3));
            u  = 2'($urandom % 2);
            c  = 4'(1 + ($urandom % 15));
            set_cfg(m, u, c);
            nl = !pin_filtered;
            if (passes_fast(m, nl)) begin
                drive_pin(nl);
                chk(m == 2'b10 ? "R7 random fast" : "R8 random fast", nl);
            end else begin
                filtered_step("R5 random filtered", nl);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule